// File: doc/BRIEF.md
# SD Card Bus Clock Divider Controller

This block derives the SD card bus clock from a faster fixed-rate input clock by dividing it by a power of two between 1 and 512. Software issues a request that carries a target frequency and two mode flags. The first flag allows an undivided pass-through. The second selects a double-data-rate timing mode in which pass-through is not used. The block chooses the smallest divisor whose output frequency does not exceed the target. It publishes the resulting 8-bit divider code, and it drives a gated card clock together with its enable.

Every change of divisor follows a fixed order. First the card clock enable drops. Then the divider finishes its current output period, and only then is the new code loaded. The new clock runs for one full period with the gate still closed, and after that the enable returns. A busy flag covers this whole window, and requests that arrive while it is set are dropped. A request with a zero target stops the card clock and leaves the divider setting as it was.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset, clk_en, busy and card_clk are 0, div_code is 0x80 (divide by 512), and the divider runs at divide by 512.
- R2: The chosen shift is found by taking the input rate divided by 512 as a candidate and doubling it while the target is at least twice the candidate, with each doubling lowering the shift by one from 9 down to 0. A target below input/256 therefore gives divide by 512.
- R3: For shift s from 2 to 9, div_code is 1 << (s-2), so 0x80 means divide by 512 and 0x01 means divide by 4. Shift 1 gives code 0x00 (divide by 2). div_code is always zero, one-hot, or all ones.
- R4: When shift 0 is chosen with pass-through enabled and the double-data-rate mode off, div_code is 0xFF and the card clock runs at the input rate: sclk_rise is 1 on every cycle.
- R5: When shift 0 is chosen with pass-through disabled, or with the double-data-rate mode on, div_code is 0x00 and the clock divides by 2.
- R6: In the cycle after a nonzero request is accepted, clk_en is 0. div_code changes only while clk_en is 0. card_clk is sclk_level gated by clk_en.
- R7: A request with target 0 that is accepted while the block is not busy sets clk_en to 0 in the next cycle, leaves busy at 0, and leaves div_code unchanged.
- R8: A new divisor is loaded only at the end of the current output period. The old period completes in full, and the first new period starts with sclk_rise.
- R9: busy is 1 from the cycle after a nonzero request until the new clock has completed its first full period. busy falls in the same cycle that clk_en rises, and the two are never 1 together.
- R10: Requests that arrive while busy is 1 are ignored.
- R11: With divisor D = 2^s, sclk_level repeats every D cycles. It is high for the first D/2 cycles of each period, or always high when D is 1. sclk_rise marks the first cycle of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock, fixed rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_freq | input | 32 | Target card clock frequency in Hz |
| req_pass_en | input | 1 | Allow undivided pass-through when shift 0 is chosen |
| req_ddr_mode | input | 1 | Double-data-rate timing mode; suppresses pass-through |
| div_code | output | 8 | Divider code currently in force |
| clk_en | output | 1 | Card clock enable |
| busy | output | 1 | Divider change in progress |
| sclk_level | output | 1 | Ungated divided clock level |
| sclk_rise | output | 1 | Marks the first cycle of each divided period |
| card_clk | output | 1 | Gated card clock |

## Verification
Two events can fall on the same cycle. The first is the end of an output period, when the divider wraps its counter. The second is the sequencer applying a pending divisor, which must wait for that wrap. The bench places requests at varied phases of the running period and across divisor jumps in both directions, including 512 down to 4 and the one-cycle period. A behavioural model that counts cycles predicts the edge at which the code, the counter restart and the gate all move, and the outputs are compared against it on every clock. A second request sent while busy checks that the overlap does not let a later request get in.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN    = 2'd0,
    SEQ_SWITCH = 2'd1,
    SEQ_SETTLE = 2'd2
  } seq_state_e;

  // number of set bits in a threshold-hit vector
  function automatic int unsigned count_set(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/sdclk_select.sv
module sdclk_select #(
  parameter longint unsigned IN_FREQ_HZ = 200_000_000,
  parameter int FREQ_W    = 32,
  parameter int MAX_SHIFT = 9,
  localparam int SH_W     = $clog2(MAX_SHIFT + 1),
  localparam int CODE_W   = MAX_SHIFT - 1
) (
  input  logic [FREQ_W-1:0] target,
  input  logic              pass_en,
  input  logic              ddr_mode,
  output logic [CODE_W-1:0] code,
  output logic [SH_W-1:0]   eff_shift
);
  import sdclk_pkg::*;

  localparam int THR_W = FREQ_W + MAX_SHIFT + 1;
  localparam logic [THR_W-1:0] BASE_V = THR_W'(IN_FREQ_HZ >> MAX_SHIFT);

  logic [THR_W-1:0]     tgt_ext;
  logic [MAX_SHIFT-1:0] hit;
  logic [SH_W-1:0]      raw_shift;

  assign tgt_ext = THR_W'(target);

  // one comparator per doubling step; the steps are monotonic
  for (genvar j = 1; j <= MAX_SHIFT; j++) begin : g_thr
    localparam logic [THR_W-1:0] THR = BASE_V << j;
    assign hit[j-1] = (tgt_ext >= THR);
  end

  always_comb begin
    raw_shift = SH_W'(MAX_SHIFT - int'(count_set(32'(hit))));
    code      = '0;
    eff_shift = raw_shift;
    if (raw_shift >= SH_W'(2)) begin
      code = CODE_W'(1) << (raw_shift - SH_W'(2));
    end else if (raw_shift == SH_W'(1)) begin
      code = '0;
    end else if (pass_en && !ddr_mode) begin
      code      = '1;
      eff_shift = '0;
    end else begin
      code      = '0;
      eff_shift = SH_W'(1);
    end
  end

endmodule

// File: rtl/sdclk_divgen.sv
module sdclk_divgen #(
  parameter int MAX_SHIFT = 9,
  localparam int SH_W     = $clog2(MAX_SHIFT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_req,
  input  logic [SH_W-1:0] new_shift,
  output logic            boundary,
  output logic            load_ack,
  output logic            level,
  output logic            rise
);

  logic [SH_W-1:0]      shift_q, shift_d;
  logic [MAX_SHIFT-1:0] cnt_q, cnt_d;
  logic [MAX_SHIFT-1:0] mask_q, mask_d, half_d;
  logic                 lvl_d, rise_d;

  assign mask_q   = {MAX_SHIFT{1'b1}} >> (MAX_SHIFT - int'(shift_q));
  assign boundary = (cnt_q == mask_q);
  assign load_ack = boundary && load_req;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q + 1'b1;
    if (boundary) begin
      cnt_d = '0;
      if (load_req) shift_d = new_shift;
    end
    mask_d = {MAX_SHIFT{1'b1}} >> (MAX_SHIFT - int'(shift_d));
    half_d = mask_d ^ (mask_d >> 1);
    lvl_d  = ((cnt_d & half_d) == '0);
    rise_d = (cnt_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= SH_W'(MAX_SHIFT);
      cnt_q   <= '0;
      level   <= 1'b1;
      rise    <= 1'b1;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      level   <= lvl_d;
      rise    <= rise_d;
    end
  end

endmodule

// File: rtl/sdclk_seq.sv
module sdclk_seq #(
  parameter int MAX_SHIFT = 9,
  localparam int SH_W     = $clog2(MAX_SHIFT + 1),
  localparam int CODE_W   = MAX_SHIFT - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_zero,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [SH_W-1:0]   sel_shift,
  input  logic              boundary,
  input  logic              load_ack,
  output logic              load_req,
  output logic [SH_W-1:0]   load_shift,
  output logic [CODE_W-1:0] code_q,
  output logic              en_q,
  output logic              busy_q
);
  import sdclk_pkg::*;

  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(1) << (CODE_W - 1);

  seq_state_e        state_q;
  logic [CODE_W-1:0] pend_code_q;
  logic [SH_W-1:0]   pend_shift_q;

  assign load_req   = (state_q == SEQ_SWITCH);
  assign load_shift = pend_shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SEQ_RUN;
      en_q         <= 1'b0;
      busy_q       <= 1'b0;
      code_q       <= RST_CODE;
      pend_code_q  <= RST_CODE;
      pend_shift_q <= SH_W'(MAX_SHIFT);
    end else begin
      case (state_q)
        SEQ_RUN: begin
          if (req_valid) begin
            en_q <= 1'b0;
            if (!req_zero) begin
              busy_q       <= 1'b1;
              pend_code_q  <= sel_code;
              pend_shift_q <= sel_shift;
              state_q      <= SEQ_SWITCH;
            end
          end
        end
        SEQ_SWITCH: begin
          if (load_ack) begin
            code_q  <= pend_code_q;
            state_q <= SEQ_SETTLE;
          end
        end
        SEQ_SETTLE: begin
          if (boundary) begin
            en_q    <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= SEQ_RUN;
          end
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl #(
  parameter longint unsigned IN_FREQ_HZ = 200_000_000,
  parameter int FREQ_W    = 32,
  parameter int MAX_SHIFT = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [FREQ_W-1:0]    req_freq,
  input  logic                 req_pass_en,
  input  logic                 req_ddr_mode,
  output logic [MAX_SHIFT-2:0] div_code,
  output logic                 clk_en,
  output logic                 busy,
  output logic                 sclk_level,
  output logic                 sclk_rise,
  output logic                 card_clk
);

  localparam int SH_W   = $clog2(MAX_SHIFT + 1);
  localparam int CODE_W = MAX_SHIFT - 1;

  logic [CODE_W-1:0] sel_code;
  logic [SH_W-1:0]   sel_shift;
  logic [SH_W-1:0]   load_shift;
  logic              load_req, load_ack, boundary;

  sdclk_select #(
    .IN_FREQ_HZ(IN_FREQ_HZ), .FREQ_W(FREQ_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_select (
    .target   (req_freq),
    .pass_en  (req_pass_en),
    .ddr_mode (req_ddr_mode),
    .code     (sel_code),
    .eff_shift(sel_shift)
  );

  sdclk_seq #(.MAX_SHIFT(MAX_SHIFT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_zero  (req_freq == '0),
    .sel_code  (sel_code),
    .sel_shift (sel_shift),
    .boundary  (boundary),
    .load_ack  (load_ack),
    .load_req  (load_req),
    .load_shift(load_shift),
    .code_q    (div_code),
    .en_q      (clk_en),
    .busy_q    (busy)
  );

  sdclk_divgen #(.MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load_req (load_req),
    .new_shift(load_shift),
    .boundary (boundary),
    .load_ack (load_ack),
    .level    (sclk_level),
    .rise     (sclk_rise)
  );

  assign card_clk = sclk_level & clk_en;

endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk #(
  parameter int FREQ_W = 32,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [FREQ_W-1:0] req_freq,
  input logic [CODE_W-1:0] div_code,
  input logic              clk_en,
  input logic              busy,
  input logic              sclk_level,
  input logic              sclk_rise,
  input logic              card_clk
);

  // R3: code is zero, one-hot, or the all-ones pass-through value
  a_r3_code_shape: assert property (@(posedge clk) disable iff (rst)
    $onehot0(div_code) || (div_code == '1));

  // R4: pass-through code implies a period start on every cycle
  a_r4_pass_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (div_code == '1) |-> sclk_rise);

  // R6: the code moves only while the gate is closed
  a_r6_code_under_gate: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_code) |-> !clk_en);

  // R6: gated clock never high with gate closed
  a_r6_gate_output: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> !card_clk);

  // R7: zero target while idle closes the gate and keeps the code
  a_r7_zero_target: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_freq == '0 && !busy) |=> (!clk_en && !busy && $stable(div_code)));

  // R9: busy and enable are exclusive, and hand over on the same edge
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && clk_en));
  a_r9_handover: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $rose(clk_en));

  // R11: a period begins with the level high
  a_r11_rise_high: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |-> sclk_level);

endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(.FREQ_W(FREQ_W), .CODE_W(MAX_SHIFT - 1)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_freq  (req_freq),
  .div_code  (div_code),
  .clk_en    (clk_en),
  .busy      (busy),
  .sclk_level(sclk_level),
  .sclk_rise (sclk_rise),
  .card_clk  (card_clk)
);

// File: tb/sdclk_ctrl_tb.sv
module sdclk_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam longint IN_HZ  = 200_000_000;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_freq = '0;
  logic        req_pass_en = 1'b0;
  logic        req_ddr_mode = 1'b0;
  logic [7:0]  div_code;
  logic        clk_en, busy, sclk_level, sclk_rise, card_clk;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdclk_ctrl #(.IN_FREQ_HZ(IN_HZ), .FREQ_W(32), .MAX_SHIFT(9)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_freq(req_freq),
    .req_pass_en(req_pass_en), .req_ddr_mode(req_ddr_mode),
    .div_code(div_code), .clk_en(clk_en), .busy(busy),
    .sclk_level(sclk_level), .sclk_rise(sclk_rise), .card_clk(card_clk)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------- behavioural reference ----------
  function automatic int pick_shift(input longint tgt);
    longint cand;
    int s;
    cand = IN_HZ / 512;
    s = 9;
    while (s > 0 && tgt >= cand * 2) begin
      cand = cand * 2;
      s--;
    end
    return s;
  endfunction

  int         m_state, m_cnt, m_shift, m_pshift;
  bit         m_en, m_busy;
  logic [7:0] m_code, m_pcode;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_cnt = 0; m_shift = 9; m_pshift = 9;
      m_en = 0; m_busy = 0; m_code = 8'h80; m_pcode = 8'h80;
    end else begin
      automatic bit bnd;
      automatic int st;
      automatic int s;
      bnd = (m_cnt == (1 << m_shift) - 1);
      st  = m_state;
      if (bnd) begin
        m_cnt = 0;
        if (st == 1) m_shift = m_pshift;
      end else begin
        m_cnt++;
      end
      if (st == 0) begin
        if (req_valid) begin
          m_en = 0;
          if (req_freq != 0) begin
            s = pick_shift(longint'(req_freq));
            m_busy = 1;
            m_state = 1;
            if (s >= 2) begin m_pcode = 8'(1 << (s - 2)); m_pshift = s; end
            else if (s == 1) begin m_pcode = 8'h00; m_pshift = 1; end
            else if (req_pass_en && !req_ddr_mode) begin m_pcode = 8'hFF; m_pshift = 0; end
            else begin m_pcode = 8'h00; m_pshift = 1; end
          end
        end
      end else if (st == 1) begin
        if (bnd) begin m_code = m_pcode; m_state = 2; end
      end else begin
        if (bnd) begin m_en = 1; m_busy = 0; m_state = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit e_lvl;
      e_lvl = (m_shift == 0) ? 1'b1 : (m_cnt < (1 << (m_shift - 1)));
      chk(div_code == m_code, "R3 code vs model", div_code, m_code);
      chk(clk_en == m_en, "R6 enable vs model", clk_en, m_en);
      chk(busy == m_busy, "R9 busy vs model", busy, m_busy);
      chk(sclk_level == e_lvl, "R11 level vs model", sclk_level, e_lvl);
      chk(sclk_rise == (m_cnt == 0), "R8 period start vs model", sclk_rise, m_cnt == 0);
      chk(card_clk == (e_lvl & m_en), "R6 gated clock vs model", card_clk, e_lvl & m_en);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  // ---------- directed helpers ----------
  task automatic do_req(input longint f, input bit p, input bit d);
    @(negedge clk);
    req_freq = 32'(f); req_pass_en = p; req_ddr_mode = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(clk_en == 1'b0, "R6 gate closed after request", clk_en, 0);
    chk(busy == (f != 0), "R9 busy after request", busy, f != 0);
    while (busy) @(negedge clk);
    if (f != 0) chk(clk_en == 1'b1, "R9 enable back at busy release", clk_en, 1);
  endtask

  task automatic measure(output int per, output int hi);
    while (!sclk_rise) @(negedge clk);
    per = 0; hi = 1;
    forever begin
      @(negedge clk);
      per++;
      if (sclk_rise) break;
      if (sclk_level) hi++;
    end
  endtask

  initial begin
    int per, hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(div_code == 8'h80, "R1 reset code", div_code, 8'h80);
    chk(!clk_en && !busy && !card_clk, "R1 reset outputs", {clk_en, busy, card_clk}, 0);

    do_req(25_000_000, 0, 0);
    chk(div_code == 8'h02, "R2 25MHz picks div8", div_code, 8'h02);
    measure(per, hi);
    chk(per == 8 && hi == 4, "R11 div8 period/high", {per, hi}, {32'd8, 32'd4});

    do_req(400_000, 0, 0);
    chk(div_code == 8'h80, "R2 400kHz below input/256 picks div512", div_code, 8'h80);
    do_req(1, 0, 0);
    chk(div_code == 8'h80, "R2 tiny target picks div512", div_code, 8'h80);

    do_req(50_000_000, 0, 0);
    chk(div_code == 8'h01, "R3 div4 code", div_code, 8'h01);
    measure(per, hi);
    chk(per == 4 && hi == 2, "R11 div4 period/high", {per, hi}, {32'd4, 32'd2});

    do_req(100_000_000, 0, 0);
    chk(div_code == 8'h00, "R3 div2 code", div_code, 8'h00);

    do_req(200_000_000, 1, 0);
    chk(div_code == 8'hFF, "R4 pass-through code", div_code, 8'hFF);
    measure(per, hi);
    chk(per == 1, "R4 pass-through period", per, 1);

    do_req(200_000_000, 1, 1);
    chk(div_code == 8'h00, "R5 ddr mode suppresses pass-through", div_code, 8'h00);
    measure(per, hi);
    chk(per == 2 && hi == 1, "R5 ddr mode divides by 2", {per, hi}, {32'd2, 32'd1});

    do_req(1_000_000_000, 0, 0);
    chk(div_code == 8'h00, "R5 no pass option gives code 0", div_code, 8'h00);

    do_req(30_000_000, 0, 0);
    chk(div_code == 8'h02, "R2 30MHz picks div8", div_code, 8'h02);
    repeat (13) @(negedge clk);

    do_req(0, 0, 0);
    chk(div_code == 8'h02 && !clk_en && !busy, "R7 zero target", {div_code, clk_en, busy}, {8'h02, 2'b00});
    repeat (5) @(negedge clk);
    chk(!card_clk, "R7 card clock held off", card_clk, 0);

    // R10: a second request during busy is dropped
    @(negedge clk);
    req_freq = 32'd50_000_000; req_pass_en = 0; req_ddr_mode = 0; req_valid = 1'b1;
    @(negedge clk);
    req_freq = 32'd200_000_000; req_pass_en = 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    chk(div_code == 8'h01, "R10 request during busy ignored", div_code, 8'h01);

    // R8: change from a long period at an odd phase
    do_req(400_000, 0, 0);
    repeat (137) @(negedge clk);
    do_req(50_000_000, 0, 0);
    chk(div_code == 8'h01, "R8 switch from div512 mid-period", div_code, 8'h01);
    repeat (20) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule